// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces DRAM refresh for a small embedded processor. A down-counter runs on the internal clock and reloads from a programmable period. Each time it runs out while the block is enabled, the block raises a memory-read refresh request toward the bus interface. The request carries a 16-bit row address, which advances once for every refresh the bus interface accepts.

The block also takes part in bus-hold arbitration. Normally an external master's hold request is granted one clock later. If a refresh falls due while the bus is granted away, the grant is withdrawn at once. The refresh is then held back until the external master has dropped its hold request for at least one clock. While a refresh is outstanding, no new grant is given.

Software sets the period through a write strobe and gates all activity with an enable level. When the internal clock rate changes, software must rewrite the period, because the count is kept in clock cycles.

Top module: `dram_refresh_timer`

## Requirements
- R1: After a synchronous reset, `rfsh_req` and `hold_grant` are 0, `rfsh_addr` is 0, and the period is `RST_PERIOD`.
- R2: With period P and the enable held high, the counter expires every P+1 clocks. The first `rfsh_req` is seen after the (P+1)-th rising edge that samples the enable high.
- R3: While `refresh_en` is 0, no request is raised. Clearing it drops a pending `rfsh_req` after the next edge. The counter waits at its reload value, so re-enabling gives a full P+1 clock delay.
- R4: A `period_wr` strobe loads `period_val` and restarts the count. With an enabled block, the next request is seen after the (Q+2)-th edge, counting the write edge.
- R5: `rfsh_req` stays high until `rfsh_ack` is sampled high, and is low after that edge when no new expiry coincides with it.
- R6: `rfsh_addr` increases by one on every edge where `rfsh_req` and `rfsh_ack` are both high, and is otherwise unchanged.
- R7: An expiry while a request is already pending is merged. After a single acknowledge, the request stays low until the next expiry.
- R8: With no refresh outstanding, `hold_grant` follows `hold_req` one clock later. While a refresh is due or being requested, `hold_grant` stays 0.
- R9: If `hold_grant` is 1 when the counter expires, `hold_grant` is 0 after that same edge.
- R10: After a grant has been withdrawn, `rfsh_req` rises only at the edge following a clock in which `hold_req` was sampled 0. `rfsh_req` and `hold_grant` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_en | input | 1 | Enable level for all refresh activity |
| period_wr | input | 1 | Strobe that loads `period_val` and restarts the count |
| period_val | input | 9 | New period value in clocks (interval is value+1) |
| rfsh_req | output | 1 | Memory-read refresh request to the bus interface |
| rfsh_addr | output | 16 | Refresh row address presented with the request |
| rfsh_ack | input | 1 | One-cycle acknowledge from the bus interface |
| hold_req | input | 1 | Hold request from the external bus master |
| hold_grant | output | 1 | Hold acknowledge to the external bus master |

## Verification
Each output comes from a single register stage. An expiry or a sampled input therefore shows up after the same edge that sees it. A request appears P+1 edges after the enable rises, and Q+2 edges after a period write. A grant follows `hold_req` one edge later, and a withdrawn grant leads to a request one edge after `hold_req` is seen low. The bench drives inputs and samples outputs on the falling clock edge. It moves in whole-edge steps counted from each stimulus, and it checks the edge just before each due point as well as the due point itself, so an early or late change is caught.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Bus arbitration state between the refresh timer and an external master
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'b00,  // bus owned by the processor, nothing due
    ARB_HELD  = 2'b01,  // bus granted to the external master
    ARB_REFR  = 2'b10,  // refresh request presented
    ARB_DRAIN = 2'b11   // refresh due, waiting for hold release
  } arb_state_e;
endpackage

// File: rtl/rfsh_interval_counter.sv
module rfsh_interval_counter #(
  parameter int PERIOD_W   = 9,
  parameter int RST_PERIOD = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                wr,
  input  logic [PERIOD_W-1:0] wr_val,
  output logic                expire
);
  localparam logic [PERIOD_W-1:0] RST_VAL = PERIOD_W'(RST_PERIOD);

  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] cnt_q;

  assign expire = en && !wr && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= RST_VAL;
      cnt_q    <= RST_VAL;
    end else if (wr) begin
      period_q <= wr_val;
      cnt_q    <= wr_val;
    end else if (!en) begin
      cnt_q <= period_q;
    end else if (cnt_q == '0) begin
      cnt_q <= period_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= period_q);  // R4
  AST_IDLE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr) |=> (cnt_q == period_q));  // R3
endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter
  import rfsh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic expire,
  input  logic ack,
  input  logic hold_req,
  output logic req,
  output logic hold_grant
);
  arb_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (en && expire)  state_n = ARB_REFR;
        else if (hold_req) state_n = ARB_HELD;
      end
      ARB_HELD: begin
        if (en && expire)   state_n = ARB_DRAIN;
        else if (!hold_req) state_n = ARB_IDLE;
      end
      ARB_DRAIN: begin
        if (!en)            state_n = hold_req ? ARB_HELD : ARB_IDLE;
        else if (!hold_req) state_n = ARB_REFR;
      end
      ARB_REFR: begin
        if (!en)         state_n = hold_req ? ARB_HELD : ARB_IDLE;
        else if (ack)    state_n = expire ? ARB_REFR
                                 : (hold_req ? ARB_HELD : ARB_IDLE);
      end
      default: state_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ARB_IDLE;
      req        <= 1'b0;
      hold_grant <= 1'b0;
    end else begin
      state_q    <= state_n;
      req        <= (state_n == ARB_REFR);
      hold_grant <= (state_n == ARB_HELD);
    end
  end

  AST_REQ_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(req && hold_grant));  // R10
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(hold_grant));  // R10
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req);  // R3
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && en) |=> req);  // R5
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
    (en && expire && hold_grant) |=> !hold_grant);  // R9
endmodule

// File: rtl/rfsh_addr_counter.sv
module rfsh_addr_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr));  // R6
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD_W   = 9,
  parameter int ADDR_W     = 16,
  parameter int RST_PERIOD = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                refresh_en,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_val,
  output logic                rfsh_req,
  output logic [ADDR_W-1:0]   rfsh_addr,
  input  logic                rfsh_ack,
  input  logic                hold_req,
  output logic                hold_grant
);
  logic expire;
  logic served;

  assign served = rfsh_req && rfsh_ack;

  rfsh_interval_counter #(
    .PERIOD_W  (PERIOD_W),
    .RST_PERIOD(RST_PERIOD)
  ) u_interval (
    .clk   (clk),
    .rst   (rst),
    .en    (refresh_en),
    .wr    (period_wr),
    .wr_val(period_val),
    .expire(expire)
  );

  rfsh_bus_arbiter u_arbiter (
    .clk       (clk),
    .rst       (rst),
    .en        (refresh_en),
    .expire    (expire),
    .ack       (rfsh_ack),
    .hold_req  (hold_req),
    .req       (rfsh_req),
    .hold_grant(hold_grant)
  );

  rfsh_addr_counter #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk (clk),
    .rst (rst),
    .step(served),
    .addr(rfsh_addr)
  );
endmodule

// File: tb/dram_refresh_timer_bench.sv
module dram_refresh_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refresh_en = 1'b0;
  logic        period_wr = 1'b0;
  logic [8:0]  period_val = '0;
  logic        rfsh_req;
  logic [15:0] rfsh_addr;
  logic        rfsh_ack = 1'b0;
  logic        hold_req = 1'b0;
  logic        hold_grant;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_timer u_dram_refresh_timer (
    .clk(clk), .rst(rst), .refresh_en(refresh_en), .period_wr(period_wr),
    .period_val(period_val), .rfsh_req(rfsh_req), .rfsh_addr(rfsh_addr),
    .rfsh_ack(rfsh_ack), .hold_req(hold_req), .hold_grant(hold_grant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance n rising edges, ending on a falling edge
  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_once();
    rfsh_ack = 1'b1; adv(1); rfsh_ack = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; adv(2); rst = 1'b0;
    chk("R1 req after reset", rfsh_req, 0);
    chk("R1 grant after reset", hold_grant, 0);
    chk("R1 addr after reset", rfsh_addr, 0);
  endtask

  task automatic t_reset_period();
    refresh_en = 1'b1;
    adv(15); chk("R1 no req before default period", rfsh_req, 0);
    adv(1);  chk("R1 req at default period", rfsh_req, 1);
    refresh_en = 1'b0; adv(1);
    chk("R3 disable drops req", rfsh_req, 0);
  endtask

  // period 5; enable edge k, expiries k+5, k+11, k+17, k+23, k+29
  task automatic t_period_ack_merge();
    period_val = 9'd5; period_wr = 1'b1; adv(1); period_wr = 1'b0;
    refresh_en = 1'b1;
    adv(5); chk("R2 no req before P+1", rfsh_req, 0);
    adv(1); chk("R2 req at P+1", rfsh_req, 1);
    chk("R6 addr with first req", rfsh_addr, 0);
    ack_once();                                         // edge k+6
    chk("R5 req drops after ack", rfsh_req, 0);
    chk("R6 addr after ack", rfsh_addr, 1);
    adv(4); chk("R2 no req before next expiry", rfsh_req, 0);
    adv(1); chk("R2 periodic req", rfsh_req, 1);        // k+11
    adv(3); chk("R5 req held without ack", rfsh_req, 1); // k+14
    adv(4);                                             // k+18, k+17 merged
    ack_once();                                         // k+19
    chk("R7 merged req cleared by one ack", rfsh_req, 0);
    chk("R6 addr after second ack", rfsh_addr, 2);
    adv(3); chk("R7 no queued req", rfsh_req, 0);        // k+22
    adv(1); chk("R7 next expiry raises req", rfsh_req, 1); // k+23
    ack_once();                                         // k+24
    chk("R6 addr after third ack", rfsh_addr, 3);
  endtask

  // expiry k+29 pending, then disable and re-enable
  task automatic t_disable();
    adv(5); chk("R2 req before disable", rfsh_req, 1);   // k+29
    refresh_en = 1'b0; adv(1);
    chk("R3 disable cancels req", rfsh_req, 0);
    adv(10); chk("R3 no req while disabled", rfsh_req, 0);
    rfsh_ack = 1'b1; adv(1); rfsh_ack = 1'b0;
    chk("R6 stray ack ignored", rfsh_addr, 3);
    refresh_en = 1'b1;                                  // enable edge j
    adv(5); chk("R3 full period after re-enable", rfsh_req, 0);
    adv(1); chk("R3 req after re-enable", rfsh_req, 1);   // j+5
    ack_once();                                         // j+6
    chk("R6 addr after re-enable ack", rfsh_addr, 4);
  endtask

  // period 3 written at edge j+9: expiries j+13, j+17, j+21, j+25
  task automatic t_write_reload();
    adv(2);
    period_val = 9'd3; period_wr = 1'b1; adv(1); period_wr = 1'b0;
    adv(3); chk("R4 old schedule discarded", rfsh_req, 0); // j+12
    adv(1); chk("R4 req Q+2 after write", rfsh_req, 1);    // j+13
    ack_once();                                            // j+14
    chk("R6 addr after reload ack", rfsh_addr, 5);
  endtask

  task automatic t_hold();
    hold_req = 1'b1; adv(1);                               // j+15
    chk("R8 grant follows hold", hold_grant, 1);
    adv(2);                                                // j+17
    chk("R9 grant withdrawn at expiry", hold_grant, 0);
    chk("R10 no req while hold kept", rfsh_req, 0);
    adv(3);                                                // j+20
    chk("R10 still waiting for release", rfsh_req, 0);
    chk("R8 no grant while refresh due", hold_grant, 0);
    hold_req = 1'b0; adv(1);                               // j+21
    chk("R10 req after hold released", rfsh_req, 1);
    hold_req = 1'b1; adv(1);                               // j+22
    chk("R8 grant withheld during req", hold_grant, 0);
    ack_once();                                            // j+23
    chk("R5 req drops after ack", rfsh_req, 0);
    chk("R8 grant after refresh done", hold_grant, 1);
    chk("R6 addr after hold refresh", rfsh_addr, 6);
    adv(2);                                                // j+25
    chk("R9 grant withdrawn again", hold_grant, 0);
    hold_req = 1'b0; adv(1);                               // j+26
    chk("R10 req after second release", rfsh_req, 1);
    ack_once();
    chk("R6 addr final", rfsh_addr, 7);
  endtask

  initial begin
    adv(1);
    t_reset();
    t_reset_period();
    t_reset();
    t_period_ack_merge();
    t_disable();
    t_write_reload();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule